// File: doc/BRIEF.md
# Strap-Preset Serial Clock Register File

This block stores the settings of a dual clock generator: three selectable video frequency words, one memory frequency word, a power-down divisor word and a 9-bit option register. Its outputs feed the clock-select and power-down logic, which are outside this block. It also contains no frequency-to-divider conversion and no PLL. The frequency words hold target frequencies in kHz.

New contents arrive serially on two asynchronous pins, a serial clock and a serial data line. Each frame carries a 3-bit address followed by a 16-bit data word. A register only changes when the last bit of a complete frame has arrived, so the video clock settings stay fixed while a frame is being shifted in. If the serial clock stops partway through a frame for longer than a set number of system cycles, the partial frame is thrown away and the receiver waits for a new frame.

Once reset is released, the four frequency words load one of four preset sets, chosen by a two-bit strap input. The strap is sampled only at that point. Pads that are left open are expected to have pull-downs, so an unconnected strap reads as 00.

Top module: `strap_serial_regfile`

## Requirements
- R1: In the first cycles after reset release, the strap value loads the following frequency words, in kHz. Strap 00: video0=25175, video1=28322, video2=28322, memory=32500. Strap 01: 25175, 28322, 28322, 40000. Strap 10: 40000, 28322, 28322, 50350. Strap 11: 40000, 50350, 50350, 56644.
- R2: After reset, the power-down divisor word reads 0 and the option register reads 9'h010. Bit 4 is the duty-adjust bit and resets to 1.
- R3: A change of the strap input after reset release has no effect on any register.
- R4: Serial bits are captured on rising edges of the serial clock. A frame is 3 address bits, MSB first, followed by 16 data bits, MSB first. The addressed register takes the data word once the 19th bit has been captured.
- R5: The address map is: 000 video0, 001 video1, 010 video2, 011 memory, 100 power-down divisor, 110 option register. The option register takes the low 9 bits of the data word.
- R6: Option register layout: bits 2..0 are the prescale-mode bits for video2, video1 and video0, with bit 0 belonging to video0. Bits 5 and 3 are reserved and always read 0, whatever is written to them.
- R7: A frame addressed to 101 or 111 changes no register.
- R8: From the first bit of a frame until its commit, busy_o is 1 and no register output changes. Between frames busy_o is 0.
- R9: If a frame gets no serial-clock rising edge for IDLE_LIM system cycles, the partial frame is discarded with no register change, and the next rising edge is taken as the first bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_i | input | 2 | Preset-set selection, sampled once after reset |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_dat_i | input | 1 | Serial data pin (asynchronous) |
| vid0_o | output | 16 | Video frequency word 0 (kHz) |
| vid1_o | output | 16 | Video frequency word 1 (kHz) |
| vid2_o | output | 16 | Video frequency word 2 (kHz) |
| mem_o | output | 16 | Memory frequency word (kHz) |
| pdiv_o | output | 16 | Power-down divisor word |
| ctl_o | output | 9 | Option register |
| busy_o | output | 1 | A serial frame is in progress |

## Verification
All four strap codes are tried across separate resets, which separates the four preset sets and shows that the power-down and option reset values do not depend on the strap. Random frames over all eight addresses with random data show whether the address decode and bit order are correct. These frames also exercise the reserved-bit masking and the ignored addresses 101 and 111. Directed runs then cover three cases: a strap change after start-up, a check in the middle of a frame that busy is high and the outputs are frozen, and a frame cut short by an idle gap followed by a clean frame, which shows that the receiver realigns.

// File: rtl/strap_serial_regfile_pkg.sv
package strap_serial_regfile_pkg;
  localparam int ADDR_W  = 3;
  localparam int FREQ_W  = 16;
  localparam int CTL_W   = 9;
  localparam int NUM_FRQ = 4;

  localparam logic [ADDR_W-1:0] ADR_PDIV = 3'b100;
  localparam logic [ADDR_W-1:0] ADR_CTL  = 3'b110;

  localparam logic [CTL_W-1:0] CTL_RESET     = 9'h010;
  localparam logic [CTL_W-1:0] CTL_RSVD_MASK = 9'h028;

  // slot 0..2 = video words, slot 3 = memory word
  function automatic logic [FREQ_W-1:0] preset_khz(input logic [1:0] strap,
                                                   input logic [1:0] slot);
    logic [FREQ_W-1:0] v;
    unique case (slot)
      2'd0:    v = strap[1] ? 16'd40000 : 16'd25175;
      2'd1,
      2'd2:    v = (strap == 2'b11) ? 16'd50350 : 16'd28322;
      default: begin
        unique case (strap)
          2'b00:   v = 16'd32500;
          2'b01:   v = 16'd40000;
          2'b10:   v = 16'd50350;
          default: v = 16'd56644;
        endcase
      end
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ssr_pin_sync.sv
module ssr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk_i,
  input  logic ser_dat_i,
  output logic rise_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_pipe_q, clk_pipe_d;
  logic [STAGES-1:0] dat_pipe_q, dat_pipe_d;
  logic              clk_prev_q;

  always_comb begin
    clk_pipe_d = {clk_pipe_q[STAGES-2:0], ser_clk_i};
    dat_pipe_d = {dat_pipe_q[STAGES-2:0], ser_dat_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe_q <= '0;
      dat_pipe_q <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_pipe_q <= clk_pipe_d;
      dat_pipe_q <= dat_pipe_d;
      clk_prev_q <= clk_pipe_q[STAGES-1];
    end
  end

  assign rise_o = clk_pipe_q[STAGES-1] & ~clk_prev_q;
  assign dat_o  = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/ssr_frame_rx.sv
module ssr_frame_rx #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 16,
  parameter int IDLE_LIM = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              dat_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int IDLE_W    = $clog2(IDLE_LIM + 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDLE_W-1:0]    idle_q, idle_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic                 wr_q, wr_d;

  always_comb begin
    cnt_d  = cnt_q;
    idle_d = idle_q;
    sh_d   = sh_q;
    wr_d   = 1'b0;
    if (rise_i) begin
      sh_d   = {sh_q[FRAME_LEN-2:0], dat_i};
      idle_d = '0;
      if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
        cnt_d = '0;
        wr_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (cnt_q != '0) begin
      if (idle_q == IDLE_W'(IDLE_LIM - 1)) begin
        cnt_d  = '0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idle_q <= '0;
      sh_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      idle_q <= idle_d;
      sh_q   <= sh_d;
      wr_q   <= wr_d;
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_addr_o = sh_q[FRAME_LEN-1 -: ADDR_W];
  assign wr_data_o = sh_q[DATA_W-1:0];
  assign busy_o    = (cnt_q != '0);
endmodule

// File: rtl/ssr_store.sv
module ssr_store
  import strap_serial_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [FREQ_W-1:0] wr_data_i,
  output logic [FREQ_W-1:0] frq_o [NUM_FRQ],
  output logic [FREQ_W-1:0] pdiv_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              init_done_o
);
  logic init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b0;
    else        init_q <= 1'b1;
  end

  for (genvar s = 0; s < NUM_FRQ; s++) begin : g_frq
    logic [FREQ_W-1:0] q, d;
    logic              en;
    always_comb begin
      en = !init_q || (wr_en_i && wr_addr_i == ADDR_W'(s));
      d  = !init_q ? preset_khz(strap_i, 2'(s)) : wr_data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign frq_o[s] = q;
  end

  logic [FREQ_W-1:0] pdiv_q;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              pdiv_en, ctl_en;

  always_comb begin
    pdiv_en = init_q && wr_en_i && (wr_addr_i == ADR_PDIV);
    ctl_en  = init_q && wr_en_i && (wr_addr_i == ADR_CTL);
    ctl_d   = wr_data_i[CTL_W-1:0] & ~CTL_RSVD_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_q <= '0;
      ctl_q  <= CTL_RESET;
    end else begin
      if (pdiv_en) pdiv_q <= wr_data_i;
      if (ctl_en)  ctl_q  <= ctl_d;
    end
  end

  assign pdiv_o      = pdiv_q;
  assign ctl_o       = ctl_q;
  assign init_done_o = init_q;
endmodule

// File: rtl/strap_serial_regfile.sv
module strap_serial_regfile #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LIM    = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap_i,
  input  logic        ser_clk_i,
  input  logic        ser_dat_i,
  output logic [15:0] vid0_o,
  output logic [15:0] vid1_o,
  output logic [15:0] vid2_o,
  output logic [15:0] mem_o,
  output logic [15:0] pdiv_o,
  output logic [8:0]  ctl_o,
  output logic        busy_o
);
  import strap_serial_regfile_pkg::*;

  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              rise, dat, wr_en, init_done;
  logic [ADDR_W-1:0] wr_addr;
  logic [FREQ_W-1:0] wr_data;
  logic [FREQ_W-1:0] frq [NUM_FRQ];

  ssr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
    .rise_o(rise), .dat_o(dat)
  );

  ssr_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(FREQ_W), .IDLE_LIM(IDLE_LIM)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .rise_i(rise), .dat_i(dat),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .busy_o(busy_o)
  );

  ssr_store u_store (
    .clk(clk), .rst_n(rst_sync_n), .strap_i(strap_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .frq_o(frq), .pdiv_o(pdiv_o), .ctl_o(ctl_o), .init_done_o(init_done)
  );

  assign vid0_o = frq[0];
  assign vid1_o = frq[1];
  assign vid2_o = frq[2];
  assign mem_o  = frq[3];
endmodule

// File: rtl/strap_serial_regfile_chk.sv
module strap_serial_regfile_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        init_done,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        busy_o,
  input logic [15:0] vid0_o,
  input logic [15:0] vid1_o,
  input logic [15:0] vid2_o,
  input logic [15:0] mem_o,
  input logic [15:0] pdiv_o,
  input logic [8:0]  ctl_o
);
  assert_hold_between_writes_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init_done && !wr_en) |=> ($stable(vid0_o) && $stable(vid1_o) && $stable(vid2_o) &&
                               $stable(mem_o) && $stable(pdiv_o) && $stable(ctl_o)));

  assert_unused_addr_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (init_done && wr_en && (wr_addr == 3'b101 || wr_addr == 3'b111)) |=>
      ($stable(vid0_o) && $stable(vid1_o) && $stable(vid2_o) &&
       $stable(mem_o) && $stable(pdiv_o) && $stable(ctl_o)));

  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_o[5] == 1'b0) && (ctl_o[3] == 1'b0));

  assert_commit_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> ($past(busy_o) && !busy_o));
endmodule

bind strap_serial_regfile strap_serial_regfile_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .init_done(init_done), .wr_en(wr_en),
  .wr_addr(wr_addr), .busy_o(busy_o), .vid0_o(vid0_o), .vid1_o(vid1_o),
  .vid2_o(vid2_o), .mem_o(mem_o), .pdiv_o(pdiv_o), .ctl_o(ctl_o)
);

// File: tb/strap_serial_regfile_tb.sv
module strap_serial_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_LIM   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap = 2'b00;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic [15:0] vid0, vid1, vid2, mem, pdiv;
  logic [8:0]  ctl;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] m_frq [4];
  logic [15:0] m_pdiv;
  logic [8:0]  m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_serial_regfile #(.SYNC_STAGES(2), .IDLE_LIM(IDLE_LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .vid0_o(vid0), .vid1_o(vid1), .vid2_o(vid2), .mem_o(mem), .pdiv_o(pdiv),
    .ctl_o(ctl), .busy_o(busy)
  );

  function automatic logic [15:0] exp_preset(input logic [1:0] s, input int slot);
    logic [15:0] t [4][4];
    t[0] = '{16'd25175, 16'd28322, 16'd28322, 16'd32500};
    t[1] = '{16'd25175, 16'd28322, 16'd28322, 16'd40000};
    t[2] = '{16'd40000, 16'd28322, 16'd28322, 16'd50350};
    t[3] = '{16'd40000, 16'd50350, 16'd50350, 16'd56644};
    return t[s][slot];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " vid0"}, 32'(vid0), 32'(m_frq[0]));
    check({req, " vid1"}, 32'(vid1), 32'(m_frq[1]));
    check({req, " vid2"}, 32'(vid2), 32'(m_frq[2]));
    check({req, " mem"},  32'(mem),  32'(m_frq[3]));
    check({req, " pdiv"}, 32'(pdiv), 32'(m_pdiv));
    check({req, " ctl"},  32'(ctl),  32'(m_ctl));
  endtask

  task automatic model_write(input logic [2:0] a, input logic [15:0] d);
    case (a)
      3'b000, 3'b001, 3'b010, 3'b011: m_frq[a] = d;
      3'b100: m_pdiv = d;
      3'b110: m_ctl = d[8:0] & 9'h1D7;
      default: ;
    endcase
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] a, input logic [15:0] d, input bit mid_check);
    logic [18:0] f;
    f = {a, d};
    for (int i = 18; i >= 0; i--) begin
      send_bit(f[i]);
      if (mid_check && i == 9) begin
        check("R8 busy mid-frame", 32'(busy), 32'd1);
        check_all("R8 frozen mid-frame");
      end
    end
    repeat (8) @(negedge clk);
    model_write(a, d);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk) rst_n = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 4; k++) m_frq[k] = exp_preset(s, k);
    m_pdiv = 16'h0000;
    m_ctl  = 9'h010;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 / R2: every strap code
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      check_all("R1 R2 preset after reset");
      check("R8 idle busy", 32'(busy), 32'd0);
    end
    // R3: strap change after start-up
    strap = 2'b00;
    repeat (10) @(negedge clk);
    check_all("R3 strap ignored");
    // R5 / R6 directed
    send_frame(3'b110, 16'hFFFF, 1'b0);
    check("R6 reserved bits masked", 32'(ctl), 32'h1D7);
    check_all("R5 ctl write");
    send_frame(3'b100, 16'h1234, 1'b1);
    check_all("R5 pdiv write");
    // R7 directed
    send_frame(3'b101, 16'hAAAA, 1'b0);
    check_all("R7 addr 101 ignored");
    send_frame(3'b111, 16'h5555, 1'b0);
    check_all("R7 addr 111 ignored");
    // R9: partial frame then idle gap
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    repeat (IDLE_LIM + 20) @(negedge clk);
    check("R9 busy cleared after idle", 32'(busy), 32'd0);
    check_all("R9 partial frame discarded");
    send_frame(3'b001, 16'h0BEE, 1'b0);
    check_all("R9 realigned frame");
    // R4 / R5 / R7 / R8 random frames
    for (int n = 0; n < 40; n++) begin
      logic [2:0]  a;
      logic [15:0] d;
      a = 3'($urandom_range(0, 7));
      d = 16'($urandom);
      send_frame(a, d, (n % 4) == 0);
      check_all("R4 R5 random frame");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule